// File: doc/BRIEF.md
# Segment Descriptor Fetch Unit

This unit turns a 16-bit protected-mode selector into a decoded segment descriptor. On a load strobe it splits the selector into a table index, a table choice bit and a requested privilege. It uses the table choice bit to pick either the global table base or the current local table base. It then forms the byte address of the 8-byte entry.

The entry is read as four 16-bit words over a plain read port. The unit raises a request, presents an address and waits for an acknowledge before it moves to the next word. Once the fourth word has arrived, the gathered words are unpacked into base, limit, type, kind, privilege and presence fields. A one-cycle completion pulse reports the result. If the top word, which must be zero, is not zero, a fault pulse is raised in place of the completion pulse. The decoded fields stay on the outputs until the words of a later fetch overwrite them.

Top module: `seg_desc_fetch`

## Requirements
- R1: While reset is held and in the first cycle after it, rd_req, done and fault are low and every decoded output is zero.
- R2: Selector bit 2 picks the table: 0 picks glob_base and 1 picks loc_base. The first read address is that base plus selector[15:3] times 8, taken modulo 2^ADDR_W.
- R3: The four words are read at the entry address, then +2, +4 and +6, lowest word first. rd_req and rd_addr hold steady in every cycle in which rd_ack is low.
- R4: seg_limit equals word 0, and seg_base equals {word 2 bits 7:0, word 1}.
- R5: seg_type equals word 2 bits 11:9, seg_is_mem equals word 2 bit 12, seg_priv equals word 2 bits 14:13, and seg_present equals word 2 bit 15.
- R6: sel_priv shows selector bits 1:0 as captured by the accepted load.
- R7: In the cycle after the acknowledge of word 3, exactly one of done or fault is high for one cycle. done is raised when word 3 is zero and fault when it is non-zero; the two are never high together.
- R8: A load strobe is ignored while a fetch is running and in the completion cycle. Such a strobe changes neither the addresses read nor sel_priv nor the decoded fields. After done or fault, rd_req stays low until the next accepted load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load | input | 1 | Start a fetch for `selector` (accepted when idle) |
| selector | input | 16 | Index, table choice bit and requested privilege |
| glob_base | input | ADDR_W | Byte base of the global table |
| loc_base | input | ADDR_W | Byte base of the current local table |
| rd_req | output | 1 | Read request for one 16-bit word |
| rd_addr | output | ADDR_W | Byte address of the requested word |
| rd_ack | input | 1 | Read acknowledge; rd_data is valid with it |
| rd_data | input | 16 | Returned word |
| seg_base | output | 24 | Decoded segment base |
| seg_limit | output | 16 | Decoded segment limit |
| seg_type | output | 3 | Decoded type field |
| seg_is_mem | output | 1 | 1 = memory segment, 0 = system object |
| seg_priv | output | 2 | Descriptor privilege |
| seg_present | output | 1 | Present bit |
| sel_priv | output | 2 | Requested privilege from the selector |
| done | output | 1 | One-cycle pulse: fetch finished cleanly |
| fault | output | 1 | One-cycle pulse: top word non-zero |

## Verification
Two events can land in the same cycle: a new load strobe and a fetch that is still running or just completing. The bench raises the strobe, with a different selector, during a read wait state and again in the completion cycle. It then judges that the remaining reads keep their expected addresses and that no new request follows. It also checks that sel_priv and the decoded fields still match the first selector. These collisions are spread across a sweep of edge and mid-range indices, both tables, all four privileges, zero to two acknowledge wait cycles, and both clean and faulting top words.

// File: rtl/segfetch_pkg.sv
// Package: shared types for the segment descriptor fetch unit.
// Assumes a 16-bit selector and a four-word, 16-bit-per-word descriptor.
package segfetch_pkg;

    localparam int SEL_W   = 16;
    localparam int WORD_W  = 16;
    localparam int N_WORDS = 4;
    localparam int IDX_W   = SEL_W - 3;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RD0  = 3'd1,
        ST_RD1  = 3'd2,
        ST_RD2  = 3'd3,
        ST_RD3  = 3'd4,
        ST_FIN  = 3'd5
    } fetch_st_t;

    typedef struct packed {
        logic [23:0] base;
        logic [15:0] limit;
        logic [2:0]  kind;
        logic        is_mem;
        logic [1:0]  priv;
        logic        present;
    } seg_desc_t;

endpackage

// File: rtl/sel_parse.sv
// Module: sel_parse
// Splits a selector on an accepted load, picks the table base and
// registers the entry byte address and the requested privilege.
// Assumes 8-byte entries; address arithmetic wraps at ADDR_W bits.
module sel_parse
    import segfetch_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [SEL_W-1:0]  selector,
    input  logic [ADDR_W-1:0] glob_base,
    input  logic [ADDR_W-1:0] loc_base,
    output logic [ADDR_W-1:0] entry_addr,
    output logic [1:0]        req_priv
);
    localparam int SHIFT = 3;

    logic [IDX_W-1:0]  idx;
    logic              use_local;
    logic [ADDR_W-1:0] tbl_base;
    logic [ADDR_W-1:0] idx_off;

    // Purpose: field split and entry address arithmetic.
    always_comb begin
        idx       = selector[SEL_W-1:3];
        use_local = selector[2];
        tbl_base  = use_local ? loc_base : glob_base;
        idx_off   = ADDR_W'(idx) << SHIFT;
    end

    // Purpose: hold the entry address and privilege for the whole fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry_addr <= '0;
            req_priv   <= '0;
        end else if (capture) begin
            entry_addr <= tbl_base + idx_off;
            req_priv   <= selector[1:0];
        end
    end

    // Privilege only moves on an accepted load (R6).
    p_priv_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(req_priv));
endmodule

// File: rtl/fetch_ctrl.sv
// Module: fetch_ctrl
// Sequencer for the four-word descriptor read.
// Each read state waits for the acknowledge before advancing, and a
// one-cycle finish state reports done or fault.
// Assumes rd_ack is only meaningful while rd_req is high.
module fetch_ctrl
    import segfetch_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       rd_ack,
    input  logic       resv_nz,
    output logic       capture,
    output logic       rd_req,
    output logic       word_we,
    output logic [1:0] word_idx,
    output logic       done,
    output logic       fault
);
    fetch_st_t st, st_nxt;

    // Purpose: next-state selection.
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE: if (load)   st_nxt = ST_RD0;
            ST_RD0:  if (rd_ack) st_nxt = ST_RD1;
            ST_RD1:  if (rd_ack) st_nxt = ST_RD2;
            ST_RD2:  if (rd_ack) st_nxt = ST_RD3;
            ST_RD3:  if (rd_ack) st_nxt = ST_FIN;
            ST_FIN:              st_nxt = ST_IDLE;
            default:             st_nxt = ST_IDLE;
        endcase
    end

    // Purpose: state register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    // Purpose: decode the state into strobes and the word index.
    always_comb begin
        capture  = (st == ST_IDLE) && load;
        rd_req   = (st == ST_RD0) || (st == ST_RD1) ||
                   (st == ST_RD2) || (st == ST_RD3);
        word_we  = rd_req && rd_ack;
        word_idx = rd_req ? 2'(st - ST_RD0) : 2'd0;
        done     = (st == ST_FIN) && !resv_nz;
        fault    = (st == ST_FIN) &&  resv_nz;
    end

    // Pulses last a single cycle (R7).
    p_pulse_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault) |=> !(done || fault));
    // No request follows a finish without a new load (R8).
    p_quiet_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault) |=> !rd_req);
endmodule

// File: rtl/desc_words.sv
// Module: desc_words
// Stores the returned words and unpacks them into the descriptor fields.
// Assumes word 0 is the lowest 16 bits of the 64-bit entry.
module desc_words
    import segfetch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_we,
    input  logic [1:0]        word_idx,
    input  logic [WORD_W-1:0] rd_data,
    output seg_desc_t         desc,
    output logic              resv_nz
);
    logic [WORD_W-1:0] w [N_WORDS];

    for (genvar g = 0; g < N_WORDS; g++) begin : g_word
        // Purpose: capture word g when it is acknowledged.
        always_ff @(posedge clk) begin
            if (!rst_n)                                  w[g] <= '0;
            else if (word_we && (word_idx == 2'(g)))     w[g] <= rd_data;
        end
    end

    // Purpose: field unpacking and the reserved-word test.
    always_comb begin
        desc.limit   = w[0];
        desc.base    = {w[2][7:0], w[1]};
        desc.kind    = w[2][11:9];
        desc.is_mem  = w[2][12];
        desc.priv    = w[2][14:13];
        desc.present = w[2][15];
        resv_nz      = |w[3];
    end

    // Decoded fields do not move without a write (R8).
    p_fields_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !word_we |=> $stable(desc));
endmodule

// File: rtl/seg_desc_fetch.sv
// Module: seg_desc_fetch (top)
// Selector-to-descriptor fetch: parse, address, four handshaked reads,
// unpack. Assumes a byte-addressed read port returning 16-bit words.
module seg_desc_fetch
    import segfetch_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [15:0]       selector,
    input  logic [ADDR_W-1:0] glob_base,
    input  logic [ADDR_W-1:0] loc_base,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [15:0]       rd_data,
    output logic [23:0]       seg_base,
    output logic [15:0]       seg_limit,
    output logic [2:0]        seg_type,
    output logic              seg_is_mem,
    output logic [1:0]        seg_priv,
    output logic              seg_present,
    output logic [1:0]        sel_priv,
    output logic              done,
    output logic              fault
);
    localparam int BYTES_PER_WORD = WORD_W / 8;

    logic              capture, word_we, resv_nz;
    logic [1:0]        word_idx;
    logic [ADDR_W-1:0] entry_addr;
    seg_desc_t         desc;

    sel_parse #(.ADDR_W(ADDR_W)) u_parse (
        .clk(clk), .rst_n(rst_n), .capture(capture), .selector(selector),
        .glob_base(glob_base), .loc_base(loc_base),
        .entry_addr(entry_addr), .req_priv(sel_priv)
    );

    fetch_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .load(load), .rd_ack(rd_ack),
        .resv_nz(resv_nz), .capture(capture), .rd_req(rd_req),
        .word_we(word_we), .word_idx(word_idx), .done(done), .fault(fault)
    );

    desc_words u_words (
        .clk(clk), .rst_n(rst_n), .word_we(word_we), .word_idx(word_idx),
        .rd_data(rd_data), .desc(desc), .resv_nz(resv_nz)
    );

    // Purpose: word address and field fan-out.
    always_comb begin
        rd_addr     = entry_addr + ADDR_W'(word_idx) * ADDR_W'(BYTES_PER_WORD);
        seg_base    = desc.base;
        seg_limit   = desc.limit;
        seg_type    = desc.kind;
        seg_is_mem  = desc.is_mem;
        seg_priv    = desc.priv;
        seg_present = desc.present;
    end

    // Request and address hold while waiting (R3).
    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));
    // Each acknowledged word but the last steps the address by 2 (R3).
    p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ack && rd_req && !(done || fault)) ##1 rd_req
        |-> rd_addr == $past(rd_addr) + ADDR_W'(2));
    // Completion and fault never together (R7).
    p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));
endmodule

// File: tb/test_seg_desc_fetch.sv
module test_seg_desc_fetch;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam logic [AW-1:0] GBASE = 32'h0012_3400;
    localparam logic [AW-1:0] LBASE = 32'hFFFF_8006;

    logic clk = 0, rst_n = 0, load = 0, rd_ack = 0;
    logic [15:0] selector = '0, rd_data = '0;
    logic [AW-1:0] glob_base = GBASE, loc_base = LBASE;
    logic rd_req, done, fault, seg_is_mem, seg_present;
    logic [AW-1:0] rd_addr;
    logic [23:0] seg_base;
    logic [15:0] seg_limit;
    logic [2:0] seg_type;
    logic [1:0] seg_priv, sel_priv;

    int checks = 0, fails = 0, cycles = 0;

    seg_desc_fetch #(.ADDR_W(AW)) i_seg_desc_fetch (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mdl(logic [AW-1:0] a);
        return a[15:0] ^ {a[23:16], a[31:24]} ^ 16'h3C5A;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            chk(0, "watchdog", 64'(cycles), 64'd150000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic run(logic [15:0] sel, bit fmode, int wait_n, bit collide);
        logic [AW-1:0] entry;
        logic [15:0] w [4];
        entry = (sel[2] ? LBASE : GBASE) + (AW'(sel[15:3]) << 3);
        @(negedge clk); selector = sel; load = 1;
        @(negedge clk); load = 0;
        for (int k = 0; k < 4; k++) begin
            w[k] = (k == 3) ? (fmode ? (mdl(entry) | 16'h1) : 16'h0)
                            : mdl(entry + AW'(2*k));
            for (int j = 0; j < wait_n; j++) begin
                chk(rd_req === 1'b1, "R3 req held", 64'(rd_req), 64'd1);
                if (collide && k == 1 && j == 0) begin
                    selector = ~sel; load = 1;     // R8 collision in read
                end
                @(negedge clk); load = 0; selector = sel;
            end
            chk(rd_req === 1'b1 && rd_addr === entry + AW'(2*k),
                (k == 0) ? "R2 entry address" : "R3 word address",
                64'(rd_addr), 64'(entry + AW'(2*k)));
            rd_ack = 1; rd_data = w[k];
            @(negedge clk); rd_ack = 0;
        end
        chk(done === !fmode && fault === fmode, "R7 done/fault",
            64'({done, fault}), 64'({!fmode, fmode}));
        chk(seg_limit === w[0], "R4 limit", 64'(seg_limit), 64'(w[0]));
        chk(seg_base === {w[2][7:0], w[1]}, "R4 base", 64'(seg_base),
            64'({w[2][7:0], w[1]}));
        chk({seg_present, seg_priv, seg_is_mem, seg_type} === w[2][15:9],
            "R5 attribute fields",
            64'({seg_present, seg_priv, seg_is_mem, seg_type}), 64'(w[2][15:9]));
        chk(sel_priv === sel[1:0], "R6 requested privilege", 64'(sel_priv),
            64'(sel[1:0]));
        if (collide) begin selector = ~sel; load = 1; end  // R8 collision at finish
        @(negedge clk); load = 0;
        chk(!rd_req && !done && !fault, "R8 quiet after finish",
            64'({rd_req, done, fault}), 64'd0);
        chk(seg_limit === w[0] && sel_priv === sel[1:0], "R8 fields kept",
            64'({seg_limit, sel_priv}), 64'({w[0], sel[1:0]}));
        @(negedge clk);
        chk(!rd_req, "R8 no request without load", 64'(rd_req), 64'd0);
    endtask

    initial begin
        logic [12:0] idxs [9];
        int n;
        idxs = '{13'h0, 13'h1, 13'h2, 13'h3, 13'h100, 13'h1555, 13'hAAA,
                 13'h1FFE, 13'h1FFF};
        repeat (3) @(negedge clk);
        chk(!rd_req && !done && !fault, "R1 reset controls",
            64'({rd_req, done, fault}), 64'd0);
        rst_n = 1;
        @(negedge clk);
        chk({seg_base, seg_limit, seg_type, seg_is_mem, seg_priv, seg_present,
             sel_priv, rd_req, done, fault} === '0, "R1 reset outputs",
            64'({seg_base, seg_limit}), 64'd0);
        n = 0;
        for (int i = 0; i < 9; i++)
            for (int t = 0; t < 2; t++)
                for (int p = 0; p < 4; p++) begin
                    run({idxs[i], t[0], p[1:0]}, (n % 5) == 4, n % 3,
                        (n % 4) == 1);
                    n++;
                end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule